// File: doc/BRIEF.md
# Two-Level Aperture Address Translator

The block maps bus addresses that land inside a graphics aperture onto physical memory addresses. Translation goes through two levels. The first is an on-chip directory of 64 entries; each entry points at one page of second-level entries in system memory, which is 1024 entries covering 4 MB of aperture at 4 KB granularity. Software loads the directory one entry per 32-bit configuration write. It also sets the aperture base, an encoded aperture size and an enable bit through the same configuration port.

A translation request is accepted through a valid/ready handshake. The request is checked against the enable bit and the aperture window, and then looked up in a small fully associative entry cache. On a miss, one 32-bit second-level entry is read from memory over a request/response port. Each request gets exactly one single-cycle response. The response carries either the translated address or a fault flag.

Top module: `aper_xlate`

## Requirements
- R1: After reset `req_ready_o` is 1, `rsp_valid_o` and `mem_req_o` are 0, and translation is disabled.
- R2: A configuration write to offset 0xB8 loads the directory entry selected by data bits 5:0. Bit 8 is the present flag and bits 31:20 are the table page address. Bits 11:9 and 7:6 have no effect on any translation.
- R3: A directory write with bit 8 clear makes that entry absent. A request that maps to an absent entry faults, and no memory read is issued.
- R4: The directory index is request bits 31:22 minus the base bits 31:22, and the table index is request bits 21:12. On a miss, `mem_req_o` pulses for one cycle, in the cycle after acceptance. `mem_addr_o` is {page[11:0], 8'h00, table index, 2'b00}.
- R5: Offset 0xB4 data bits 7:0 set the aperture size. The codes map to 64/32/16/8 directory entries: code 0 for 256 MB, 32 for 128 MB, 48 for 64 MB and 56 for 32 MB. Any other code accepts no address.
- R6: A request below the base, or at or beyond base plus size, faults in the cycle after acceptance and issues no memory read.
- R7: In the cycle after `mem_rsp_valid_i`, the response is given. If data bit 0 is 1, the result is {data[31:12], request bits 11:0} with no fault. If bit 0 is 0, the response is a fault with address 0.
- R8: The entry cache holds 4 translations and replaces in round-robin order. A hit answers in the cycle after acceptance with no memory read. A fifth distinct page evicts the oldest filled entry.
- R9: Offset 0xB0 bit 7 enables translation; while it is 0, every request faults with no memory read. A write there with bit 7 clear empties the cache. A write to the base register at offset 0x10 (data bits 31:22) also empties the cache.
- R10: A directory write drops every cached translation that came through that directory index. Other cached translations stay.
- R11: `req_ready_o` is 0 in any cycle with `cfg_we_i` high and while a memory read is outstanding.
- R12: A second-level entry with bit 0 clear is never cached, so a repeat of the same request reads memory again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration register offset |
| cfg_wdata_i | input | 32 | Configuration write data |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Translation request accepted when high with valid |
| req_addr_i | input | 32 | Bus address to translate |
| rsp_valid_o | output | 1 | Single-cycle response strobe |
| rsp_addr_o | output | 32 | Translated physical address |
| rsp_fault_o | output | 1 | Translation fault |
| mem_req_o | output | 1 | Second-level entry read strobe |
| mem_addr_o | output | 32 | Second-level entry word address |
| mem_rsp_valid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | 32 | Second-level entry read data |

## Verification
Faults and cache hits are due one cycle after acceptance. A miss shows `mem_req_o` one cycle after acceptance, and the response is due one cycle after the memory data strobe. The bench therefore samples at the falling edge after each accepting or data edge, and it checks that no response appears earlier. The memory latency is random from zero to three cycles, so the bench confirms the walk waits for the data rather than a fixed delay. The bench keeps its own model of the directory and of the round-robin cache, and uses it to predict whether each request reads memory.

// File: rtl/aper_pkg.sv
`timescale 1ns/1ps
package aper_pkg;
  localparam logic [7:0] OFS_BASE = 8'h10;
  localparam logic [7:0] OFS_CTRL = 8'hB0;
  localparam logic [7:0] OFS_SIZE = 8'hB4;
  localparam logic [7:0] OFS_DIR  = 8'hB8;
  localparam int         CTRL_EN_BIT = 7;
  localparam int         NDIR_W = 7;

  typedef struct packed {
    logic        present;
    logic [11:0] page;
  } dir_ent_t;

  typedef enum logic {ST_IDLE, ST_WAIT} walk_st_e;

  function automatic logic [NDIR_W-1:0] size_to_ndir(input logic [7:0] code);
    case (code)
      8'd0:    return 7'd64;
      8'd32:   return 7'd32;
      8'd48:   return 7'd16;
      8'd56:   return 7'd8;
      default: return 7'd0;
    endcase
  endfunction
endpackage

// File: rtl/aper_cfg.sv
`timescale 1ns/1ps
module aper_cfg
  import aper_pkg::*;
#(
  parameter int DIR_N  = 64,
  parameter int DIR_IW = $clog2(DIR_N)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [7:0]          cfg_addr_i,
  input  logic [31:0]         cfg_wdata_i,
  input  logic [DIR_IW-1:0]   lookup_idx_i,
  output dir_ent_t            lookup_o,
  output logic [9:0]          base_o,
  output logic [NDIR_W-1:0]   ndir_o,
  output logic                enable_o,
  output logic                flush_o,
  output logic                dir_wr_o,
  output logic [DIR_IW-1:0]   dir_wr_idx_o
);
  dir_ent_t    dir_q [DIR_N];
  logic [9:0]  base_q;
  logic [7:0]  size_q;
  logic        en_q;
  logic        wr_base, wr_ctrl, wr_size;
  logic        unused_cfg;

  assign unused_cfg   = ^cfg_wdata_i[19:9];
  assign wr_base      = cfg_we_i && (cfg_addr_i == OFS_BASE);
  assign wr_ctrl      = cfg_we_i && (cfg_addr_i == OFS_CTRL);
  assign wr_size      = cfg_we_i && (cfg_addr_i == OFS_SIZE);
  assign dir_wr_o     = cfg_we_i && (cfg_addr_i == OFS_DIR);
  assign dir_wr_idx_o = cfg_wdata_i[DIR_IW-1:0];
  // clearing the enable bit or moving the window invalidates cached results
  assign flush_o      = (wr_ctrl && !cfg_wdata_i[CTRL_EN_BIT]) || wr_base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      size_q <= 8'hFF;
      en_q   <= 1'b0;
      for (int i = 0; i < DIR_N; i++) dir_q[i] <= '0;
    end else begin
      if (wr_base)  base_q <= cfg_wdata_i[31:22];
      if (wr_size)  size_q <= cfg_wdata_i[7:0];
      if (wr_ctrl)  en_q   <= cfg_wdata_i[CTRL_EN_BIT];
      if (dir_wr_o) dir_q[dir_wr_idx_o] <= '{present: cfg_wdata_i[8], page: cfg_wdata_i[31:20]};
    end
  end

  assign lookup_o = dir_q[lookup_idx_i];
  assign base_o   = base_q;
  assign ndir_o   = size_to_ndir(size_q);
  assign enable_o = en_q;

  assert_dir_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_wr_o |=> (dir_q[$past(dir_wr_idx_o)].present == $past(cfg_wdata_i[8])));
endmodule

// File: rtl/aper_tlb.sv
`timescale 1ns/1ps
module aper_tlb #(
  parameter int N      = 4,
  parameter int DIR_IW = 6,
  parameter int PW     = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [19:0]       lk_vpn_i,
  output logic              hit_o,
  output logic [19:0]       hit_ppn_o,
  input  logic              ins_i,
  input  logic [19:0]       ins_vpn_i,
  input  logic [DIR_IW-1:0] ins_dir_i,
  input  logic [19:0]       ins_ppn_i,
  input  logic              flush_i,
  input  logic              inv_i,
  input  logic [DIR_IW-1:0] inv_dir_i
);
  logic [N-1:0]      v_q;
  logic [19:0]       vpn_q [N];
  logic [19:0]       ppn_q [N];
  logic [DIR_IW-1:0] dir_q [N];
  logic [PW-1:0]     ptr_q;
  logic [N-1:0]      hit_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q   <= '0;
      ptr_q <= '0;
      for (int e = 0; e < N; e++) begin
        vpn_q[e] <= '0;
        ppn_q[e] <= '0;
        dir_q[e] <= '0;
      end
    end else begin
      for (int e = 0; e < N; e++) begin
        if (flush_i) begin
          v_q[e] <= 1'b0;
        end else if (ins_i && ptr_q == PW'(e)) begin
          v_q[e]   <= 1'b1;
          vpn_q[e] <= ins_vpn_i;
          ppn_q[e] <= ins_ppn_i;
          dir_q[e] <= ins_dir_i;
        end else if (inv_i && dir_q[e] == inv_dir_i) begin
          v_q[e] <= 1'b0;
        end
      end
      if (ins_i && !flush_i) ptr_q <= (ptr_q == PW'(N-1)) ? '0 : ptr_q + 1'b1;
    end
  end

  for (genvar e = 0; e < N; e++) begin : g_cmp
    assign hit_vec[e] = v_q[e] && (vpn_q[e] == lk_vpn_i);
  end

  always_comb begin
    hit_ppn_o = '0;
    for (int e = 0; e < N; e++) if (hit_vec[e]) hit_ppn_o |= ppn_q[e];
  end
  assign hit_o = |hit_vec;

  assert_unique_tag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
endmodule

// File: rtl/aper_walk.sv
`timescale 1ns/1ps
module aper_walk
  import aper_pkg::*;
#(
  parameter int DIR_IW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [31:0]       req_addr_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_addr_o,
  output logic              rsp_fault_o,
  output logic              mem_req_o,
  output logic [31:0]       mem_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [31:0]       mem_rdata_i,
  input  logic              cfg_we_i,
  input  logic              enable_i,
  input  logic [9:0]        base_i,
  input  logic [NDIR_W-1:0] ndir_i,
  output logic [DIR_IW-1:0] dir_idx_o,
  input  dir_ent_t          dir_ent_i,
  input  logic              dir_wr_i,
  input  logic [DIR_IW-1:0] dir_wr_idx_i,
  input  logic              flush_i,
  input  logic              tlb_hit_i,
  input  logic [19:0]       tlb_ppn_i,
  output logic              ins_o,
  output logic [19:0]       ins_vpn_o,
  output logic [DIR_IW-1:0] ins_dir_o,
  output logic [19:0]       ins_ppn_o
);
  walk_st_e          state_q;
  logic [11:0]       off_q;
  logic [19:0]       vpn_q;
  logic [DIR_IW-1:0] dir_q;
  logic              stale_q;
  logic [10:0]       diff;
  logic              in_win, accept, stale_now;
  logic              unused_rdata;

  assign unused_rdata = ^mem_rdata_i[11:1];

  // borrow in bit 10 marks an address below the base
  assign diff      = {1'b0, req_addr_i[31:22]} - {1'b0, base_i};
  assign in_win    = enable_i && !diff[10] && (diff[9:0] < {3'b000, ndir_i});
  assign dir_idx_o = diff[DIR_IW-1:0];

  assign req_ready_o = (state_q == ST_IDLE) && !cfg_we_i;
  assign accept      = req_valid_i && req_ready_o;

  // a fill whose directory entry changed mid-walk must not land in the cache
  assign stale_now = stale_q || flush_i || (dir_wr_i && dir_wr_idx_i == dir_q);
  assign ins_o     = (state_q == ST_WAIT) && mem_rsp_valid_i && mem_rdata_i[0] && !stale_now;
  assign ins_vpn_o = vpn_q;
  assign ins_dir_o = dir_q;
  assign ins_ppn_o = mem_rdata_i[31:12];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      off_q       <= '0;
      vpn_q       <= '0;
      dir_q       <= '0;
      stale_q     <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_addr_o  <= '0;
      rsp_fault_o <= 1'b0;
      mem_req_o   <= 1'b0;
      mem_addr_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      mem_req_o   <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          if (!in_win) begin
            rsp_valid_o <= 1'b1;
            rsp_fault_o <= 1'b1;
            rsp_addr_o  <= '0;
          end else if (tlb_hit_i) begin
            rsp_valid_o <= 1'b1;
            rsp_fault_o <= 1'b0;
            rsp_addr_o  <= {tlb_ppn_i, req_addr_i[11:0]};
          end else if (!dir_ent_i.present) begin
            rsp_valid_o <= 1'b1;
            rsp_fault_o <= 1'b1;
            rsp_addr_o  <= '0;
          end else begin
            mem_req_o  <= 1'b1;
            mem_addr_o <= {dir_ent_i.page, 8'h00, req_addr_i[21:12], 2'b00};
            off_q      <= req_addr_i[11:0];
            vpn_q      <= req_addr_i[31:12];
            dir_q      <= dir_idx_o;
            stale_q    <= 1'b0;
            state_q    <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          stale_q <= stale_now;
          if (mem_rsp_valid_i) begin
            rsp_valid_o <= 1'b1;
            rsp_fault_o <= !mem_rdata_i[0];
            rsp_addr_o  <= mem_rdata_i[0] ? {mem_rdata_i[31:12], off_q} : 32'h0;
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_cfg_stall_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && cfg_we_i) |=> (!rsp_valid_o && !mem_req_o));
  assert_mem_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  assert_wait_for_data_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !mem_rsp_valid_i) |=> !rsp_valid_o);
  assert_window_fault_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !in_win) |=> (rsp_valid_o && rsp_fault_o && !mem_req_o));
endmodule

// File: rtl/aper_xlate.sv
`timescale 1ns/1ps
module aper_xlate
  import aper_pkg::*;
#(
  parameter int DIR_N = 64,
  parameter int TLB_N = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [7:0]  cfg_addr_i,
  input  logic [31:0] cfg_wdata_i,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [31:0] req_addr_i,
  output logic        rsp_valid_o,
  output logic [31:0] rsp_addr_o,
  output logic        rsp_fault_o,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_rsp_valid_i,
  input  logic [31:0] mem_rdata_i
);
  localparam int DIR_IW = $clog2(DIR_N);

  dir_ent_t          dir_ent;
  logic [DIR_IW-1:0] dir_idx, dir_wr_idx, ins_dir;
  logic [9:0]        base;
  logic [NDIR_W-1:0] ndir;
  logic              enable, flush, dir_wr;
  logic              tlb_hit, ins;
  logic [19:0]       tlb_ppn, ins_vpn, ins_ppn;

  aper_cfg #(.DIR_N(DIR_N), .DIR_IW(DIR_IW)) u_cfg (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .lookup_idx_i(dir_idx), .lookup_o(dir_ent), .base_o(base), .ndir_o(ndir),
    .enable_o(enable), .flush_o(flush), .dir_wr_o(dir_wr), .dir_wr_idx_o(dir_wr_idx)
  );

  aper_tlb #(.N(TLB_N), .DIR_IW(DIR_IW)) u_tlb (
    .clk_i, .rst_ni, .lk_vpn_i(req_addr_i[31:12]), .hit_o(tlb_hit), .hit_ppn_o(tlb_ppn),
    .ins_i(ins), .ins_vpn_i(ins_vpn), .ins_dir_i(ins_dir), .ins_ppn_i(ins_ppn),
    .flush_i(flush), .inv_i(dir_wr), .inv_dir_i(dir_wr_idx)
  );

  aper_walk #(.DIR_IW(DIR_IW)) u_walk (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_addr_i,
    .rsp_valid_o, .rsp_addr_o, .rsp_fault_o, .mem_req_o, .mem_addr_o,
    .mem_rsp_valid_i, .mem_rdata_i, .cfg_we_i, .enable_i(enable), .base_i(base),
    .ndir_i(ndir), .dir_idx_o(dir_idx), .dir_ent_i(dir_ent), .dir_wr_i(dir_wr),
    .dir_wr_idx_i(dir_wr_idx), .flush_i(flush), .tlb_hit_i(tlb_hit), .tlb_ppn_i(tlb_ppn),
    .ins_o(ins), .ins_vpn_o(ins_vpn), .ins_dir_o(ins_dir), .ins_ppn_o(ins_ppn)
  );
endmodule

// File: tb/aper_xlate_bench.sv
`timescale 1ns/1ps
module aper_xlate_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0; logic [7:0] cfg_addr = 0; logic [31:0] cfg_wdata = 0;
  logic req_valid = 0; logic [31:0] req_addr = 0;
  logic mem_rsp_valid = 0; logic [31:0] mem_rdata = 0;
  logic req_ready, rsp_valid, rsp_fault, mem_req;
  logic [31:0] rsp_addr, mem_addr;

  always #5 clk = ~clk;

  aper_xlate u_aper_xlate (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .rsp_valid_o(rsp_valid), .rsp_addr_o(rsp_addr),
    .rsp_fault_o(rsp_fault), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rdata_i(mem_rdata)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  logic [9:0]  m_base = 0;
  int          m_ndir = 0;
  bit          m_en = 0;
  bit          m_dp [64];
  logic [11:0] m_dpg [64];
  bit          c_v [4];
  logic [19:0] c_vpn [4];
  logic [19:0] c_ppn [4];
  logic [5:0]  c_dir [4];
  int          c_ptr = 0;

  localparam logic [31:0] BASE = 32'hE000_0000;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int ndir_of(input logic [7:0] c);
    case (c)
      8'd0: return 64; 8'd32: return 32; 8'd48: return 16; 8'd56: return 8;
      default: return 0;
    endcase
  endfunction

  // second-level entries: table index with low bits 2'b11 is invalid
  function automatic logic [31:0] pte_of(input logic [31:0] fa);
    logic [31:0] x;
    x = fa * 32'h9E37_79B1;
    return {x[31:12], 11'h0, (fa[3:2] != 2'b11)};
  endfunction

  task automatic flush_model();
    for (int i = 0; i < 4; i++) c_v[i] = 0;
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    #1;
    chk(req_ready == 1'b0, "R11 ready during cfg write", {31'b0, req_ready}, 0);
    @(negedge clk);
    cfg_we = 0;
    case (a)
      8'hB8: begin
        m_dp[d[5:0]] = d[8]; m_dpg[d[5:0]] = d[31:20];
        for (int i = 0; i < 4; i++) if (c_dir[i] == d[5:0]) c_v[i] = 0;
      end
      8'h10: begin m_base = d[31:22]; flush_model(); end
      8'hB4: m_ndir = ndir_of(d[7:0]);
      8'hB0: begin m_en = d[7]; if (!d[7]) flush_model(); end
      default: ;
    endcase
  endtask

  task automatic predict(input logic [31:0] a, output bit f, output logic [31:0] pa,
                         output bit miss, output logic [31:0] fa, output logic [5:0] di);
    logic [10:0] d; logic [31:0] pte;
    f = 1; pa = 0; miss = 0; fa = 0;
    d = {1'b0, a[31:22]} - {1'b0, m_base};
    di = d[5:0];
    if (!m_en || d[10] || int'(d[9:0]) >= m_ndir) return;
    for (int i = 0; i < 4; i++)
      if (c_v[i] && c_vpn[i] == a[31:12]) begin f = 0; pa = {c_ppn[i], a[11:0]}; return; end
    if (!m_dp[di]) return;
    miss = 1;
    fa = {m_dpg[di], 8'h00, a[21:12], 2'b00};
    pte = pte_of(fa);
    if (pte[0]) begin f = 0; pa = {pte[31:12], a[11:0]}; end
  endtask

  task automatic xlate(input logic [31:0] a, input string tag);
    bit ef, em; logic [31:0] ep, efa; logic [5:0] di; int lat;
    predict(a, ef, ep, em, efa, di);
    @(negedge clk);
    req_valid = 1; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(mem_req == em, {tag, " R8 memory read issued"}, {31'b0, mem_req}, {31'b0, em});
    if (mem_req) begin
      chk(mem_addr == efa, {tag, " R4 fetch address"}, mem_addr, efa);
      chk(rsp_valid == 0, {tag, " R7 no early response"}, {31'b0, rsp_valid}, 0);
      chk(req_ready == 0, {tag, " R11 ready low during walk"}, {31'b0, req_ready}, 0);
      lat = $urandom % 4;
      repeat (lat) begin
        @(negedge clk);
        chk(rsp_valid == 0, {tag, " R7 wait for data"}, {31'b0, rsp_valid}, 0);
      end
      mem_rsp_valid = 1; mem_rdata = pte_of(efa);
      @(posedge clk);
      @(negedge clk);
      mem_rsp_valid = 0;
    end
    chk(rsp_valid == 1, {tag, " R7 response strobe"}, {31'b0, rsp_valid}, 1);
    chk(rsp_fault == ef, {tag, " R6 fault flag"}, {31'b0, rsp_fault}, {31'b0, ef});
    chk(rsp_addr == ep, {tag, " R7 result address"}, rsp_addr, ep);
    if (em && !ef) begin
      c_v[c_ptr] = 1; c_vpn[c_ptr] = a[31:12]; c_ppn[c_ptr] = ep[31:12]; c_dir[c_ptr] = di;
      c_ptr = (c_ptr + 1) % 4;
    end
  endtask

  function automatic logic [31:0] va(input int dir, input int idx, input int off);
    return BASE + (dir << 22) + (idx << 12) + off;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ef; logic [31:0] ep, efa; bit em; logic [5:0] di;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) begin m_dp[i] = 0; m_dpg[i] = 0; end
    for (int i = 0; i < 4; i++) begin c_v[i] = 0; c_dir[i] = 0; c_vpn[i] = 0; c_ppn[i] = 0; end
    repeat (3) @(negedge clk);
    chk(req_ready == 1, "R1 reset ready", {31'b0, req_ready}, 1);
    chk(rsp_valid == 0, "R1 reset rsp_valid", {31'b0, rsp_valid}, 0);
    chk(mem_req == 0, "R1 reset mem_req", {31'b0, mem_req}, 0);
    rst_n = 1;
    cfg_wr(8'h10, BASE);
    cfg_wr(8'hB4, 32'd0);
    for (int i = 0; i < 10; i++) cfg_wr(8'hB8, {12'(12'h100 + i), 11'h0, 1'b1, 2'b00, 6'(i)});
    xlate(va(0, 0, 12'h10), "R1 disabled");
    chk(rsp_fault == 1, "R9 disabled faults", {31'b0, rsp_fault}, 1);
    cfg_wr(8'hB0, 32'h80);

    // R2: ignored attribute and reserved bits
    cfg_wr(8'hB8, {12'hABC, 8'h00, 3'b111, 1'b1, 2'b11, 6'd9});
    xlate(va(9, 1, 12'h234), "R2 packed dir write");
    chk(mem_addr == {12'hABC, 8'h00, 10'd1, 2'b00}, "R2 page field", mem_addr,
        {12'hABC, 8'h00, 10'd1, 2'b00});
    // R3: absent directory entry
    cfg_wr(8'hB8, {12'hABC, 11'h0, 1'b0, 2'b00, 6'd9});
    xlate(va(9, 2, 0), "R3 absent dir");
    chk(rsp_fault == 1 && mem_req == 0, "R3 fault no read", {31'b0, rsp_fault}, 1);

    // R8 round robin
    cfg_wr(8'hB0, 32'h00); cfg_wr(8'hB0, 32'h80);
    xlate(va(0, 0, 1), "R8 fill0"); xlate(va(0, 1, 2), "R8 fill1");
    xlate(va(0, 2, 3), "R8 fill2"); xlate(va(0, 4, 4), "R8 fill3");
    xlate(va(0, 0, 5), "R8 hit0");
    xlate(va(0, 5, 6), "R8 evict0");
    xlate(va(0, 1, 7), "R8 hit1 kept");
    xlate(va(0, 0, 8), "R8 refetch0");
    // R12 invalid entry never cached
    xlate(va(1, 3, 0), "R12 first");
    xlate(va(1, 3, 0), "R12 again");
    chk(mem_req == 1 || rsp_fault == 1, "R12 repeated read", {31'b0, rsp_fault}, 1);
    // R10 directory write drops matching entries only
    cfg_wr(8'hB0, 32'h00); cfg_wr(8'hB0, 32'h80);
    xlate(va(1, 0, 0), "R10 fill d1"); xlate(va(2, 0, 0), "R10 fill d2");
    cfg_wr(8'hB8, {12'h101, 11'h0, 1'b1, 2'b00, 6'd1});
    xlate(va(1, 0, 0), "R10 d1 refetch"); xlate(va(2, 0, 0), "R10 d2 hit");
    // R9 flush through base write
    cfg_wr(8'h10, BASE);
    xlate(va(2, 0, 0), "R9 base flush refetch");
    cfg_wr(8'hB0, 32'h00);
    xlate(va(2, 0, 0), "R9 disabled");
    cfg_wr(8'hB0, 32'h80);
    // R5 sizes and R6 window edges
    cfg_wr(8'hB4, 32'd56);
    xlate(va(7, 0, 0), "R5 last dir of 32MB");
    xlate(va(8, 0, 0), "R5 beyond 32MB");
    xlate(BASE - 32'h1000, "R6 below base");
    cfg_wr(8'hB4, 32'h11);
    xlate(va(0, 0, 0), "R5 bad size code");
    cfg_wr(8'hB4, 32'd48);
    xlate(va(15, 0, 0), "R5 64MB edge"); xlate(va(16, 0, 0), "R6 64MB beyond");
    cfg_wr(8'hB4, 32'd0);
    xlate(va(63, 0, 0), "R5 256MB top");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom % 100;
      if (r < 10) begin
        logic [31:0] dd;
        dd = $urandom;
        cfg_wr(8'hB8, {dd[31:20], dd[19:9], (($urandom % 5) != 0), dd[7:6], 6'($urandom % 8)});
      end else if (r < 13) begin
        cfg_wr(8'hB0, 32'h00); cfg_wr(8'hB0, 32'h80);
      end else if (r < 17) begin
        xlate(BASE - (($urandom % 4 + 1) << 22), "R6 random below");
      end else begin
        xlate(va($urandom % 10, $urandom % 8, $urandom % 4096), "R7 random");
      end
    end
    predict(va(0, 0, 0), ef, ep, em, efa, di);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule